// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator

This block collects 64 interrupt request lines and combines them into one interrupt line for a processor. The lines are split into two banks of 32: bank 0 takes lines 0 to 31 and bank 1 takes lines 32 to 63. Every bank keeps a sticky event register, an enable mask and a copy of the present input levels. A fixed per-bank constant, set at reset, decides whether each line is edge-latched or level-driven. Software masks lines and acknowledges events through a small register bus that decodes a 4 KiB window.

A line that is edge-latched sets its event bit when it rises, and that bit stays set until software acknowledges it. A level-driven line passes its present level straight into the pending value. Its event bit is never set, and an acknowledge cannot clear it. The processor interrupt is high whenever any unmasked bit of either bank is pending.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Input line n belongs to bank n/32, at bit n%32 of that bank's registers.
- R2: The pending value of a bank is (events | (levels & level_sel)) & mask. `cpu_irq` is high exactly when either bank's pending value is nonzero, computed from the registered state.
- R3: The bank index is ((addr & 0xFFF) - 0x10) >> 4, computed in 12-bit arithmetic. Bank 0 therefore answers at 0x10-0x1F and bank 1 at 0x20-0x2F. Any other index, including the wrapped result of addresses below 0x10, is ignored on write and reads as zero.
- R4: A write at in-bank offset 0x4 loads the mask with `bus_wdata` on the clock edge. `cpu_irq` reflects the new mask in the next cycle.
- R5: A write at offset 0x8 clears every event bit whose `bus_wdata` bit is 1, unless that line is level-driven.
- R6: An acknowledge never clears a level-driven line. While such a line stays high and unmasked, `cpu_irq` stays high after the acknowledge.
- R7: A write at any in-bank offset other than 0x4 or 0x8 changes no state.
- R8: At reset, bank 0 has no level-driven lines and bank 1 has level selection 0x1FF00000. Lines 52 to 60 are therefore level-driven.
- R9: The levels register takes the present input vector on each clock edge.
- R10: Reset clears events, mask and levels in both banks, and `cpu_irq` is then low.
- R11: For an edge-latched line, a low-to-high change seen between the levels register and the input sets its event bit. The bit stays set after the input falls, until it is acknowledged.
- R12: A read returns events at offset 0x0, mask at 0x4, levels at 0xC and zero at any other offset. The read data is combinational, is zero when no read is presented, and has no side effects.
- R13: When a rising edge and an acknowledge of the same bit meet in one cycle, the event bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request levels, line n at bit n |
| bus_valid | input | 1 | Register access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| cpu_irq | output | 1 | Combined interrupt to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same cycle as a rising edge on the bit it clears. The same applies to an acknowledge aimed at a level-driven line that is still asserted. Directed sequences build both situations on purpose: they hold the line low, then raise it in the very cycle the acknowledge write is presented. A random phase then mixes line toggles with writes and reads across the whole low address range. That range includes the wrapped addresses below 0x10 and the offsets outside the register set.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_BANKS  = 2;
    localparam int BANK_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int WIN_BASE   = 16;
    localparam int BANK_SHIFT = 4;

    typedef enum logic [3:0] {
        OFF_EVENTS = 4'h0,
        OFF_MASK   = 4'h4,
        OFF_ACK    = 4'h8,
        OFF_LEVELS = 4'hC
    } reg_off_e;

    // which lines of a bank are level-driven after reset
    function automatic logic [BANK_W-1:0] level_sel_default(input int bank);
        return (bank == 1) ? 32'h1FF0_0000 : '0;
    endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
    parameter int ADDR_W     = 12,
    parameter int NUM_BANKS  = 2,
    parameter int WIN_BASE   = 16,
    parameter int BANK_SHIFT = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output logic [3:0]           reg_off
);
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        rel     = addr - ADDR_W'(WIN_BASE);
        idx     = rel >> BANK_SHIFT;
        reg_off = addr[3:0];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        assign bank_hit[b] = (idx == ADDR_W'(b));
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int               W       = 32,
    parameter logic [W-1:0]     LVL_SEL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mask,
    input  logic         wr_ack,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] irq_lvl,
    output logic [W-1:0] events,
    output logic [W-1:0] mask,
    output logic [W-1:0] levels,
    output logic         pending
);
    typedef struct packed {
        logic [W-1:0] events;
        logic [W-1:0] mask;
        logic [W-1:0] levels;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [W-1:0] rise_d, clr_d;

    always_comb begin
        st_d        = st_q;
        rise_d      = irq_lvl & ~st_q.levels & ~LVL_SEL;
        clr_d       = wr_ack ? (wdata & ~LVL_SEL) : '0;
        st_d.events = (st_q.events & ~clr_d) | rise_d;
        if (wr_mask) st_d.mask = wdata;
        st_d.levels = irq_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign events  = st_q.events;
    assign mask    = st_q.mask;
    assign levels  = st_q.levels;
    assign pending = |((st_q.events | (st_q.levels & LVL_SEL)) & st_q.mask);

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask == $past(wdata)));  // R4
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (levels == $past(irq_lvl)));  // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> ((events & $past(wdata) & ~LVL_SEL & ~levels) == '0));  // R5
    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ack |=> ((events & $past(events)) == $past(events)));  // R11
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irqc_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W,
    parameter int AW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB*BW-1:0] irq_in,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BW-1:0]    bus_wdata,
    output logic [BW-1:0]    bus_rdata,
    output logic             cpu_irq
);
    logic [NB-1:0] hit, wr_mask, wr_ack, pend;
    logic [3:0]    off;
    logic [BW-1:0] ev_a [NB];
    logic [BW-1:0] mk_a [NB];
    logic [BW-1:0] lv_a [NB];
    logic          wr_en, rd_en, any_mask;

    assign wr_en = bus_valid & bus_write;
    assign rd_en = bus_valid & ~bus_write;

    irqc_decode #(
        .ADDR_W(AW), .NUM_BANKS(NB), .WIN_BASE(WIN_BASE), .BANK_SHIFT(BANK_SHIFT)
    ) u_dec (
        .addr(bus_addr), .bank_hit(hit), .reg_off(off)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign wr_mask[b] = wr_en & hit[b] & (off == OFF_MASK);
        assign wr_ack[b]  = wr_en & hit[b] & (off == OFF_ACK);
        irqc_bank #(.W(BW), .LVL_SEL(level_sel_default(b))) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_mask(wr_mask[b]), .wr_ack(wr_ack[b]),
            .wdata(bus_wdata), .irq_lvl(irq_in[b*BW +: BW]),
            .events(ev_a[b]), .mask(mk_a[b]), .levels(lv_a[b]),
            .pending(pend[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        any_mask  = 1'b0;
        for (int b = 0; b < NB; b++) begin
            any_mask = any_mask | (|mk_a[b]);
            if (rd_en && hit[b]) begin
                case (off)
                    OFF_EVENTS: bus_rdata = ev_a[b];
                    OFF_MASK:   bus_rdata = mk_a[b];
                    OFF_LEVELS: bus_rdata = lv_a[b];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    assign cpu_irq = |pend;

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> any_mask);  // R2
    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (bus_rdata == '0));  // R12
    AST_OTHER_OFF_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off != OFF_MASK) |=> (mk_a[0] == $past(mk_a[0]) && mk_a[1] == $past(mk_a[1])));  // R7
    AST_ONE_BANK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));  // R3
endmodule

// File: tb/tb_irq_bank_ctrl.sv
`timescale 1ns/1ps
module tb_irq_bank_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [63:0] irq_in = '0;
    logic        bus_valid = 0, bus_write = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] m_ev [2];
    logic [31:0] m_mk [2];
    logic [31:0] m_lv [2];
    localparam logic [31:0] LT0 = 32'h0, LT1 = 32'h1FF0_0000;

    always #2.5 clk = ~clk;

    irq_bank_ctrl dut (.*);

    function automatic logic [31:0] lt_of(int b);
        return (b == 1) ? LT1 : LT0;
    endfunction

    function automatic int bank_of(logic [11:0] a);
        logic [11:0] r;
        r = (a - 12'h010) >> 4;
        return (r < 2) ? int'(r) : -1;
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        int b;
        b = bank_of(a);
        if (b < 0) return '0;
        case (a[3:0])
            4'h0: return m_ev[b];
            4'h4: return m_mk[b];
            4'hC: return m_lv[b];
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_irq();
        logic r;
        r = 0;
        for (int b = 0; b < 2; b++)
            r |= |((m_ev[b] | (m_lv[b] & lt_of(b))) & m_mk[b]);
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: advance the model with the inputs presented, then check the output
    task automatic step(string req);
        logic [31:0] ne [2], nm [2], nl [2];
        for (int b = 0; b < 2; b++) begin
            logic [31:0] lvl, rise, clr;
            lvl  = irq_in[b*32 +: 32];
            rise = lvl & ~m_lv[b] & ~lt_of(b);
            clr  = (bus_valid && bus_write && bank_of(bus_addr) == b && bus_addr[3:0] == 4'h8)
                   ? (bus_wdata & ~lt_of(b)) : '0;
            ne[b] = (m_ev[b] & ~clr) | rise;
            nm[b] = (bus_valid && bus_write && bank_of(bus_addr) == b && bus_addr[3:0] == 4'h4)
                   ? bus_wdata : m_mk[b];
            nl[b] = lvl;
        end
        @(posedge clk);
        for (int b = 0; b < 2; b++) begin
            m_ev[b] = ne[b]; m_mk[b] = nm[b]; m_lv[b] = nl[b];
        end
        #1;
        chk(req, {31'b0, cpu_irq}, {31'b0, exp_irq()});
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string req);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        step(req);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(logic [11:0] a, string req);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_read(a));
        step(req);
        bus_valid = 0;
        #0.5;
        chk("R12 idle", bus_rdata, '0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int b = 0; b < 2; b++) begin m_ev[b] = 0; m_mk[b] = 0; m_lv[b] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10 irq at reset", {31'b0, cpu_irq}, '0);
        rst_n = 1;
        step("R10");
        foreach (m_ev[b]) begin
            rd(12'h010 + 12'(b * 16), "R10 events zero");
            rd(12'h014 + 12'(b * 16), "R10 mask zero");
            rd(12'h01C + 12'(b * 16), "R10 levels zero");
        end

        // R11, R1, R2, R4: edge latch on line 0 (bank 0 bit 0)
        wr(12'h014, 32'h1, "R4 mask bank0");
        rd(12'h014, "R4 mask readback");
        irq_in[0] = 1; step("R2 edge raises irq");
        chk("R11 irq set", {31'b0, cpu_irq}, 32'h1);
        irq_in[0] = 0; step("R11 sticky");
        chk("R11 sticky after fall", {31'b0, cpu_irq}, 32'h1);
        rd(12'h010, "R11 events bit0");
        wr(12'h018, 32'h1, "R5 ack");
        chk("R5 cleared irq", {31'b0, cpu_irq}, 32'h0);

        // R1, R8, R6, R9: line 52 is level-driven (bank1 bit20)
        wr(12'h024, 32'h0010_0000, "R4 mask bank1");
        irq_in[52] = 1; step("R8 level high");
        chk("R8 level irq", {31'b0, cpu_irq}, 32'h1);
        rd(12'h020, "R1 R8 no event for level line");
        rd(12'h02C, "R9 levels readback");
        wr(12'h028, 32'hFFFF_FFFF, "R6 ack level");
        chk("R6 irq held", {31'b0, cpu_irq}, 32'h1);
        irq_in[52] = 0; step("R8 level low");
        chk("R8 level drop", {31'b0, cpu_irq}, 32'h0);
        // line 51 is edge-latched in bank 1
        wr(12'h024, 32'h0008_0000, "R4");
        irq_in[51] = 1; step("R1 line51");
        irq_in[51] = 0; step("R11 line51 sticky");
        chk("R1 line51 irq", {31'b0, cpu_irq}, 32'h1);
        wr(12'h028, 32'h0008_0000, "R5 ack bank1");

        // R7: other offsets ignored
        wr(12'h01C, 32'hDEAD_BEEF, "R7 write levels offset");
        wr(12'h010, 32'hDEAD_BEEF, "R7 write events offset");
        rd(12'h014, "R7 mask unchanged");
        rd(12'h010, "R7 events unchanged");
        // R3: out-of-window writes and reads
        wr(12'h004, 32'hFFFF_FFFF, "R3 low addr write");
        wr(12'h034, 32'hFFFF_FFFF, "R3 bank2 write");
        rd(12'h014, "R3 bank0 mask unchanged");
        rd(12'h024, "R3 bank1 mask unchanged");
        irq_in[3] = 1; step("R3"); irq_in[3] = 0; step("R3");
        rd(12'h000, "R3 wrapped read zero");
        rd(12'h030, "R3 bank2 read zero");
        rd(12'h018, "R12 ack offset reads zero");

        // R13: edge and ack in the same cycle
        wr(12'h014, 32'h8, "R13 mask");
        wr(12'h018, 32'h8, "R13 pre-clear");
        bus_valid = 1; bus_write = 1; bus_addr = 12'h018; bus_wdata = 32'h8;
        irq_in[3] = 1;
        step("R13 collision");
        bus_valid = 0; bus_write = 0;
        rd(12'h010, "R13 event survives");
        chk("R13 irq", {31'b0, cpu_irq}, 32'h1);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int k;
            k = $urandom_range(0, 9);
            if ($urandom_range(0, 3) == 0) irq_in[$urandom_range(0, 63)] ^= 1'b1;
            if (k < 3) begin
                wr(12'($urandom_range(0, 63)), $urandom(), "R5 R7 random write");
            end else if (k < 6) begin
                rd(12'($urandom_range(0, 63)), "R12 random read");
            end else begin
                step("R2 random");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule